// File: doc/BRIEF.md
# Shadowed Configuration Register Bank with Frame-Synchronous Commit

This block holds a small bank of display configuration registers in two copies. Software only ever writes the shadow copy, through a single-cycle write port with a per-bit mask. The pipeline only ever sees the active copy. The whole shadow bank moves into the active copy in one clock edge, on a vertical-blank strobe, so a frame never starts with half of an update.

A control write carries two bits, a load request and an autoload-off flag. A load request does not change the active registers at once. It stays visible as a pending status bit until the next vertical blank copies the bank, and hardware then clears it. Software polls that bit before it begins the next update.

When autoload is left on, every vertical blank copies the bank whether or not a request was made. When autoload is off, only a pending request causes a copy. Reads always return the shadow value, so read-modify-write sequences work on the copy being prepared. The masked write lets software change one field without touching the other bits.

Top module: `regbank_commit`

## Requirements
- R1: After reset, every shadow and active register reads zero, load_pending is 0 and autoload_off is 0 (autoload on).
- R2: A write with wr_en high and wr_addr below NUM_REGS sets each shadow bit whose wr_mask bit is 1 to the matching wr_data bit and keeps the others. rd_data shows the new value from the next cycle. The active copy does not change.
- R3: A control write with ctrl_load_req=1 raises load_pending on the next cycle. load_pending stays high, and the active copy stays unchanged, for as long as no vblank arrives.
- R4: When vblank is high while load_pending is 1, every active register takes the shadow value at that edge, and load_pending reads 0 afterwards.
- R5: With autoload_off=0, every vblank copies the whole shadow bank into the active copy, even when no request is pending.
- R6: With autoload_off=1 and no pending request, a vblank leaves the active copy unchanged.
- R7: A shadow write in the same cycle as a copying vblank does not reach the active copy in that frame. The active register gets the value it had before the write, and the written value moves at the next copy.
- R8: A load request in the same cycle as a copying vblank is not consumed by it. load_pending is 1 afterwards, and the next vblank performs a copy.
- R9: Writes to addresses NUM_REGS and above change nothing, and reads of those addresses return zero.
- R10: A control write always sets autoload_off to ctrl_autoload_off. A control write with ctrl_load_req=0 leaves load_pending as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Shadow register write strobe |
| wr_addr | input | ADDR_W | Shadow register write index |
| wr_data | input | DATA_W | Write data |
| wr_mask | input | DATA_W | Per-bit write enable |
| rd_addr | input | ADDR_W | Read index |
| rd_data | output | DATA_W | Shadow value at rd_addr, zero if out of range |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_load_req | input | 1 | Control: request a copy at the next vblank |
| ctrl_autoload_off | input | 1 | Control: new autoload-off flag |
| vblank | input | 1 | One-cycle vertical blank strobe |
| load_pending | output | 1 | Load request not yet served |
| autoload_off | output | 1 | Current autoload-off flag |
| active_cfg | output | NUM_REGS*DATA_W | Active register copy, register 0 in the low bits |

## Verification
The collisions that matter are a vblank copy together with a shadow write, and a vblank copy together with a new load request. The bench drives each pair onto the same clock edge. It then judges the result in two steps. First, after that edge, the active copy must hold the value from before the write, and the pending bit must be set. Second, after the following vblank, the written value must appear in the active copy and the pending bit must be clear. A per-cycle model in the bench, built only from the requirements, supplies the expected shadow, active and status values. These are compared on every register after each step, across full-mask writes, partial-mask writes and out-of-range writes.

// File: rtl/regbank_commit.sv
module regbank_commit #(
  parameter int NUM_REGS = 12,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [DATA_W-1:0]          wr_mask,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  input  logic                       ctrl_wr,
  input  logic                       ctrl_load_req,
  input  logic                       ctrl_autoload_off,
  input  logic                       vblank,
  output logic                       load_pending,
  output logic                       autoload_off,
  output logic [NUM_REGS*DATA_W-1:0] active_cfg
);

  logic [DATA_W-1:0]          shadow_q [NUM_REGS];
  logic [NUM_REGS*DATA_W-1:0] shadow_flat;
  logic                       copy_now;

  assign copy_now = vblank & (load_pending | ~autoload_off);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_pending <= 1'b0;
      autoload_off <= 1'b0;
    end else begin
      load_pending <= (ctrl_wr & ctrl_load_req) | (load_pending & ~copy_now);
      if (ctrl_wr) autoload_off <= ctrl_autoload_off;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow_q[g] <= '0;
      end else if (hit) begin
        shadow_q[g] <= (shadow_q[g] & ~wr_mask) | (wr_data & wr_mask);
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        active_cfg[g*DATA_W +: DATA_W] <= '0;
      end else if (copy_now) begin
        active_cfg[g*DATA_W +: DATA_W] <= shadow_q[g];
      end
    end

    assign shadow_flat[g*DATA_W +: DATA_W] = shadow_q[g];
  end

  assign rd_data = (32'(rd_addr) < NUM_REGS) ? shadow_q[rd_addr] : '0;

endmodule

// File: rtl/regbank_commit_chk.sv
module regbank_commit_chk #(
  parameter int NUM_REGS = 12,
  parameter int DATA_W   = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ctrl_wr,
  input logic                       ctrl_load_req,
  input logic                       vblank,
  input logic                       load_pending,
  input logic                       autoload_off,
  input logic [NUM_REGS*DATA_W-1:0] active_cfg,
  input logic [NUM_REGS*DATA_W-1:0] shadow_flat
);

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    load_pending && !vblank |=> load_pending); // R3

  AST_ACT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !vblank |=> $stable(active_cfg)); // R3

  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    load_pending && vblank && !(ctrl_wr && ctrl_load_req) |=> !load_pending); // R4

  AST_COPY_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    vblank && (load_pending || !autoload_off) |=> active_cfg == $past(shadow_flat)); // R4

  AST_NOAUTO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    vblank && !load_pending && autoload_off |=> $stable(active_cfg)); // R6

  AST_REQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && ctrl_load_req |=> load_pending); // R8

endmodule

bind regbank_commit regbank_commit_chk #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .ctrl_wr(ctrl_wr),
  .ctrl_load_req(ctrl_load_req),
  .vblank(vblank),
  .load_pending(load_pending),
  .autoload_off(autoload_off),
  .active_cfg(active_cfg),
  .shadow_flat(shadow_flat)
);

// File: tb/regbank_commit_tb.sv
`timescale 1ns/1ps
module regbank_commit_tb;
  localparam int  NR    = 12;
  localparam int  DW    = 16;
  localparam int  AW    = 4;
  localparam real CLK_P = 10.0;
  localparam int  WD    = 50000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0, wr_mask = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic ctrl_wr = 1'b0, ctrl_load_req = 1'b0, ctrl_autoload_off = 1'b0, vblank = 1'b0;
  logic load_pending, autoload_off;
  logic [NR*DW-1:0] active_cfg;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] m_sh [NR];
  logic [DW-1:0] m_ac [NR];
  logic m_pend = 1'b0;
  logic m_off  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  regbank_commit #(.NUM_REGS(NR), .DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_mask(wr_mask), .rd_addr(rd_addr), .rd_data(rd_data), .ctrl_wr(ctrl_wr),
    .ctrl_load_req(ctrl_load_req), .ctrl_autoload_off(ctrl_autoload_off),
    .vblank(vblank), .load_pending(load_pending), .autoload_off(autoload_off),
    .active_cfg(active_cfg)
  );

  function automatic logic [DW-1:0] pat(input int i, input int k);
    return DW'((i * 32'h1357 + k * 32'h0F1 + 7) ^ 32'hA5A5);
  endfunction

  task automatic cmp(input string tag, input string what, input int idx,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s[%0d] got %h expected %h", tag, what, idx, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int a = 0; a < (1 << AW); a++) begin
      rd_addr = AW'(a);
      #0.2;
      cmp(tag, "rd", a, rd_data, (a < NR) ? m_sh[a] : '0);
    end
    for (int r = 0; r < NR; r++) cmp(tag, "active", r, active_cfg[r*DW +: DW], m_ac[r]);
    cmp(tag, "pending", 0, DW'(load_pending), DW'(m_pend));
    cmp(tag, "autoload_off", 0, DW'(autoload_off), DW'(m_off));
  endtask

  task automatic step(input logic we, input int addr, input logic [DW-1:0] d,
                      input logic [DW-1:0] m, input logic cw, input logic cl,
                      input logic co, input logic vb);
    logic cp;
    @(negedge clk);
    wr_en = we; wr_addr = AW'(addr); wr_data = d; wr_mask = m;
    ctrl_wr = cw; ctrl_load_req = cl; ctrl_autoload_off = co; vblank = vb;
    @(posedge clk);
    cp = vb && (m_pend || !m_off);
    if (cp) for (int r = 0; r < NR; r++) m_ac[r] = m_sh[r];
    if (we && addr < NR) m_sh[addr] = (m_sh[addr] & ~m) | (d & m);
    m_pend = (cw && cl) || (m_pend && !cp);
    if (cw) m_off = co;
    #1;
    wr_en = 0; ctrl_wr = 0; ctrl_load_req = 0; vblank = 0;
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d, input logic [DW-1:0] m);
    step(1, a, d, m, 0, 0, 0, 0);
  endtask
  task automatic ctl(input logic load, input logic off);
    step(0, 0, '0, '0, 1, load, off, 0);
  endtask
  task automatic vbl();
    step(0, 0, '0, '0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] masks [4];
    masks[0] = 16'h00FF; masks[1] = 16'hFF00; masks[2] = 16'h0F0F; masks[3] = 16'h8001;
    for (int r = 0; r < NR; r++) begin m_sh[r] = '0; m_ac[r] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    check_all("R1");

    ctl(0, 1); check_all("R10");
    for (int i = 0; i < NR; i++) begin wr(i, pat(i, 0), '1); check_all("R2"); end
    for (int i = 0; i < NR; i++)
      for (int k = 0; k < 4; k++) begin wr(i, pat(i, k + 1), masks[k]); check_all("R2"); end

    vbl(); check_all("R6");
    ctl(1, 1); check_all("R3");
    for (int n = 0; n < 3; n++) begin step(0, 0, '0, '0, 0, 0, 0, 0); check_all("R3"); end
    ctl(0, 1); check_all("R10");
    vbl(); check_all("R4");
    vbl(); check_all("R6");

    for (int i = 0; i < NR; i++) wr(i, pat(i, 9), '1);
    ctl(1, 1);
    step(1, 2, 16'hBEEF, '1, 0, 0, 0, 1); check_all("R7");
    ctl(1, 1); vbl(); check_all("R7");

    ctl(1, 1);
    wr(5, 16'h1234, '1);
    step(0, 0, '0, '0, 1, 1, 1, 1); check_all("R8");
    wr(5, 16'h4321, 16'hF0F0);
    vbl(); check_all("R8");
    vbl(); check_all("R6");

    for (int a = NR; a < (1 << AW); a++) begin wr(a, 16'hFFFF, '1); check_all("R9"); end

    ctl(0, 0); check_all("R10");
    for (int f = 0; f < 4; f++) begin
      for (int i = 0; i < NR; i++) wr(i, pat(i, 20 + f), masks[f]);
      vbl(); check_all("R5");
    end
    step(1, 7, 16'h5A5A, '1, 0, 0, 0, 1); check_all("R7");
    vbl(); check_all("R5");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule